// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Controller

This block is the control logic that lets a five-stage pipeline settle conditional branches in the decode stage. The branch operands are compared in decode, so the comparator needs fresh data. The block chooses when each comparator input takes the result held in the EX/MEM pipeline register instead of the register file value. It holds the front of the pipe when an operand is still being produced. It discards the one instruction fetched behind a taken branch or a jump.

All outputs are a pure function of the current cycle's pipeline-register fields. They act on the PC, the IF/ID register and the ID/EX control inputs in the same cycle. The register file, the comparator datapath and the target adder are outside the block. The comparator result arrives as `cmp_hit`, which is already adjusted for the branch sense, so `cmp_hit` high means "this branch is taken". Results written by the instruction in writeback need no path here. The register file writes in the first half of the cycle and reads in the second.

Top module: `br_hazard_ctl`

## Requirements
- R1: `fwd_a` is 1 exactly when `dec_branch`=1, `mem_wr_en`=1, `mem_dst`≠0 and `mem_dst`=`dec_src_a`. 1 selects the EX/MEM result for comparator input A.
- R2: `fwd_b` is 1 exactly when `dec_branch`=1, `mem_wr_en`=1, `mem_dst`≠0 and `mem_dst`=`dec_src_b`.
- R3: Register number 0 is never treated as a dependency. A destination of 0 in EX or in MEM causes no forwarding and no stall.
- R4: If `dec_branch`=1, `ex_wr_en`=1, `ex_dst`≠0 and `ex_dst` equals either source, then `pc_wr_en`=0 and `ifid_wr_en`=0 in that cycle.
- R5: `id_bubble` is 1 in exactly those cycles in which the pipe front is held; otherwise `pc_wr_en`=`ifid_wr_en`=1.
- R6: If `dec_branch`=1, `mem_load`=1, `mem_wr_en`=1, `mem_dst`≠0 and `mem_dst` equals either source, the front is held as in R4.
- R7: A load that writes a branch operand holds the branch for two successive cycles: one with the load in EX and one with it in MEM. The branch proceeds in the following cycle.
- R8: `if_flush` is 1 when `dec_branch`=1 and `cmp_hit`=1 and the front is not held.
- R9: `if_flush` is 1 whenever `dec_jump`=1. A jump is never held.
- R10: A hold takes priority over a flush. `if_flush` and `id_bubble` are never 1 together, and `cmp_hit` has no effect while held.
- R11: When `dec_branch`=0, `fwd_a`, `fwd_b` and `id_bubble` are 0, whatever the EX and MEM fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_branch | input | 1 | Instruction in decode is a conditional branch |
| dec_jump | input | 1 | Instruction in decode is a jump |
| dec_src_a | input | REG_AW | First source register number in IF/ID |
| dec_src_b | input | REG_AW | Second source register number in IF/ID |
| ex_dst | input | REG_AW | Destination register of the instruction in EX |
| ex_wr_en | input | 1 | Instruction in EX writes a register |
| mem_dst | input | REG_AW | Destination register of the instruction in MEM |
| mem_wr_en | input | 1 | Instruction in MEM writes a register |
| mem_load | input | 1 | Instruction in MEM is a load |
| cmp_hit | input | 1 | Comparator says the branch is taken |
| fwd_a | output | 1 | Comparator input A takes the EX/MEM result |
| fwd_b | output | 1 | Comparator input B takes the EX/MEM result |
| pc_wr_en | output | 1 | PC may update |
| ifid_wr_en | output | 1 | IF/ID register may update |
| id_bubble | output | 1 | Zero the controls entering ID/EX |
| if_flush | output | 1 | Turn the instruction entering IF/ID into a no-op |

## Verification
Every result is due in the same cycle as the fields that cause it. No register lies between any input and any output. The bench applies each input pattern on the falling clock edge and samples all six outputs 2 ns later, before the next rising edge. Each output is compared with a value the bench works out from the requirements. The sweep covers every legal flag combination over four register numbers, including register 0. A separate two-cycle sequence then models a load moving from EX to MEM. It checks the hold in both cycles and the release in the third.

// File: rtl/br_hazard_pkg.sv
package br_hazard_pkg;
  // number of comparator operands served by the forwarding logic
  localparam int unsigned NUM_OPS = 2;

  typedef enum logic [1:0] {
    HOLD_NONE   = 2'd0,
    HOLD_EX     = 2'd1,
    HOLD_MEMLD  = 2'd2,
    HOLD_BOTH   = 2'd3
  } hold_src_e;
endpackage

// File: rtl/br_fwd_sel.sv
module br_fwd_sel #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              is_branch,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  output logic              sel_mem
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live;
  assign dst_live = mem_wr_en && (mem_dst != ZERO_REG);
  assign sel_mem  = is_branch && dst_live && (mem_dst == src);

  always_comb begin
    AST_FWD_NEEDS_LIVE_DST: assert (!sel_mem || (mem_dst != ZERO_REG && mem_wr_en)) else $error("fwd with dead dst"); // R3
  end
endmodule

// File: rtl/br_hold_det.sv
module br_hold_det #(
  parameter int unsigned REG_AW = 5
) (
  input  logic                    is_branch,
  input  logic [REG_AW-1:0]       src_a,
  input  logic [REG_AW-1:0]       src_b,
  input  logic [REG_AW-1:0]       ex_dst,
  input  logic                    ex_wr_en,
  input  logic [REG_AW-1:0]       mem_dst,
  input  logic                    mem_wr_en,
  input  logic                    mem_load,
  output br_hazard_pkg::hold_src_e hold_src,
  output logic                    hold
);
  import br_hazard_pkg::*;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic ex_hit, memld_hit;

  assign ex_hit = is_branch && ex_wr_en && (ex_dst != ZERO_REG) &&
                  ((ex_dst == src_a) || (ex_dst == src_b));

  assign memld_hit = is_branch && mem_load && mem_wr_en && (mem_dst != ZERO_REG) &&
                     ((mem_dst == src_a) || (mem_dst == src_b));

  always_comb begin
    unique case ({memld_hit, ex_hit})
      2'b01:   hold_src = HOLD_EX;
      2'b10:   hold_src = HOLD_MEMLD;
      2'b11:   hold_src = HOLD_BOTH;
      default: hold_src = HOLD_NONE;
    endcase
  end

  assign hold = (hold_src != HOLD_NONE);

  always_comb begin
    AST_HOLD_ONLY_BRANCH: assert (!hold || is_branch) else $error("hold without branch"); // R11
  end
endmodule

// File: rtl/br_hazard_ctl.sv
module br_hazard_ctl #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              dec_branch,
  input  logic              dec_jump,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic              mem_load,
  input  logic              cmp_hit,
  output logic              fwd_a,
  output logic              fwd_b,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              id_bubble,
  output logic              if_flush
);
  import br_hazard_pkg::*;

  logic [REG_AW-1:0] src_vec [NUM_OPS];
  logic [NUM_OPS-1:0] fwd_vec;
  hold_src_e hold_src;
  logic hold;

  assign src_vec[0] = dec_src_a;
  assign src_vec[1] = dec_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_fwd
    br_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
      .is_branch (dec_branch),
      .src       (src_vec[g]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .sel_mem   (fwd_vec[g])
    );
  end

  br_hold_det #(.REG_AW(REG_AW)) u_hold (
    .is_branch (dec_branch),
    .src_a     (dec_src_a),
    .src_b     (dec_src_b),
    .ex_dst    (ex_dst),
    .ex_wr_en  (ex_wr_en),
    .mem_dst   (mem_dst),
    .mem_wr_en (mem_wr_en),
    .mem_load  (mem_load),
    .hold_src  (hold_src),
    .hold      (hold)
  );

  assign fwd_a      = fwd_vec[0];
  assign fwd_b      = fwd_vec[1];
  assign pc_wr_en   = !hold;
  assign ifid_wr_en = !hold;
  assign id_bubble  = hold;
  assign if_flush   = dec_jump || (dec_branch && cmp_hit && !hold);

  always_comb begin
    AST_FLUSH_NOT_WITH_BUBBLE: assert (!(if_flush && id_bubble)) else $error("flush during hold"); // R10
    AST_ENABLES_AGREE: assert (pc_wr_en == ifid_wr_en) else $error("enables split"); // R5
    AST_NO_FWD_OFF_BRANCH: assert (dec_branch || fwd_vec == '0) else $error("fwd off branch"); // R11
    AST_BRANCH_HOLD_KIND: assert (!hold || hold_src != HOLD_NONE) else $error("hold kind"); // R4
  end
endmodule

// File: tb/br_hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module br_hazard_ctl_tb_top;
  localparam int unsigned AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic dec_branch, dec_jump, ex_wr_en, mem_wr_en, mem_load, cmp_hit;
  logic [AW-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst;
  logic fwd_a, fwd_b, pc_wr_en, ifid_wr_en, id_bubble, if_flush;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  br_hazard_ctl #(.REG_AW(AW)) dut_i (
    .dec_branch(dec_branch), .dec_jump(dec_jump),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .ex_dst(ex_dst), .ex_wr_en(ex_wr_en),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en), .mem_load(mem_load),
    .cmp_hit(cmp_hit),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_wr_en(pc_wr_en),
    .ifid_wr_en(ifid_wr_en), .id_bubble(id_bubble), .if_flush(if_flush)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b br=%b j=%b a=%0d b=%0d ex=%0d/%b mem=%0d/%b/%b cmp=%b",
               req, what, act, exp, dec_branch, dec_jump, dec_src_a, dec_src_b,
               ex_dst, ex_wr_en, mem_dst, mem_wr_en, mem_load, cmp_hit);
    end
  endtask

  task automatic drive(input logic br, input logic j, input int a, input int b,
                       input int ed, input logic ew, input int md, input logic mw,
                       input logic ml, input logic c);
    @(negedge clk);
    dec_branch = br; dec_jump = j;
    dec_src_a = AW'(a); dec_src_b = AW'(b);
    ex_dst = AW'(ed); ex_wr_en = ew;
    mem_dst = AW'(md); mem_wr_en = mw; mem_load = ml; cmp_hit = c;
    #2;
  endtask

  // expected values straight from the requirements
  task automatic check_all();
    logic e_fa, e_fb, e_exh, e_mlh, e_hold, e_fl;
    e_fa  = dec_branch && mem_wr_en && mem_dst != 0 && mem_dst == dec_src_a;          // R1
    e_fb  = dec_branch && mem_wr_en && mem_dst != 0 && mem_dst == dec_src_b;          // R2
    e_exh = dec_branch && ex_wr_en && ex_dst != 0 &&
            (ex_dst == dec_src_a || ex_dst == dec_src_b);                             // R4
    e_mlh = dec_branch && mem_load && mem_wr_en && mem_dst != 0 &&
            (mem_dst == dec_src_a || mem_dst == dec_src_b);                           // R6
    e_hold = e_exh || e_mlh;
    e_fl  = dec_jump || (dec_branch && cmp_hit && !e_hold);                           // R8 R9 R10
    chk(dec_branch ? "R1" : "R11", "fwd_a", fwd_a, e_fa);
    chk(dec_branch ? "R2" : "R11", "fwd_b", fwd_b, e_fb);
    chk(e_mlh ? "R6" : "R4", "pc_wr_en", pc_wr_en, !e_hold);
    chk("R5", "ifid_wr_en", ifid_wr_en, !e_hold);
    chk("R5", "id_bubble", id_bubble, e_hold);
    chk(dec_jump ? "R9" : (e_hold ? "R10" : "R8"), "if_flush", if_flush, e_fl);
  endtask

  initial begin
    dec_branch = 0; dec_jump = 0; dec_src_a = 0; dec_src_b = 0;
    ex_dst = 0; ex_wr_en = 0; mem_dst = 0; mem_wr_en = 0; mem_load = 0; cmp_hit = 0;

    // idle state: nothing in flight
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", "idle pc_wr_en", pc_wr_en, 1'b1);
    chk("R5", "idle id_bubble", id_bubble, 1'b0);
    chk("R8", "idle if_flush", if_flush, 1'b0);

    // register zero corner: destinations 0 match sources 0 but are no dependency
    drive(1, 0, 0, 0, 0, 1, 0, 1, 1, 1);
    chk("R3", "r0 fwd_a", fwd_a, 1'b0);
    chk("R3", "r0 id_bubble", id_bubble, 1'b0);
    chk("R3", "r0 if_flush", if_flush, 1'b1);

    // sweep: four register numbers per field, all legal flag combinations
    for (int fl = 0; fl < 64; fl++) begin
      if (fl[0] && fl[1]) continue; // branch and jump together cannot occur
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int ed = 0; ed < 4; ed++)
            for (int md = 0; md < 4; md++) begin
              drive(fl[0], fl[1], a, b, ed, fl[2], md, fl[3], fl[4] & fl[3], fl[5]);
              check_all();
            end
    end

    // R7: load writing operand 3 moves EX -> MEM -> WB while branch waits
    drive(1, 0, 3, 1, 3, 1, 0, 0, 0, 1);
    chk("R7", "ld in EX pc_wr_en", pc_wr_en, 1'b0);
    chk("R7", "ld in EX if_flush", if_flush, 1'b0);
    drive(1, 0, 3, 1, 0, 0, 3, 1, 1, 1);
    chk("R7", "ld in MEM pc_wr_en", pc_wr_en, 1'b0);
    chk("R7", "ld in MEM id_bubble", id_bubble, 1'b1);
    drive(1, 0, 3, 1, 0, 0, 0, 0, 0, 1);
    chk("R7", "ld retired pc_wr_en", pc_wr_en, 1'b1);
    chk("R7", "ld retired if_flush", if_flush, 1'b1);

    // R1: non-load producer in MEM forwards instead of holding
    drive(1, 0, 7, 9, 0, 0, 7, 1, 0, 0);
    chk("R1", "alu in MEM fwd_a", fwd_a, 1'b1);
    chk("R1", "alu in MEM pc_wr_en", pc_wr_en, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule